// File: doc/BRIEF.md
# Command-Engine Logic Operation Unit

This unit carries out the arithmetic and bitwise instruction of a command engine that runs several hardware threads side by side. Each thread owns a small bank of 32-bit scratch registers. An instruction names a thread, a destination register, a 4-bit operation and two operands. Each operand is either a 16-bit literal or a pointer to one of the issuing thread's scratch registers. The unit reads the operands, computes the result and writes it back into the destination register of the same thread. The commonest use is to load a constant that later commands use as a value, mask or address.

Instructions enter through a valid/ready handshake and can be issued back to back. A result is committed one cycle after the handshake. A forwarding path makes it visible at once to the next instruction and to the observation read port, so a dependent instruction never stalls. Operation codes outside the defined set leave every register alone and raise a one-cycle error pulse.

Top module: `spr_alu`

## Requirements
- R1: After reset every scratch register of every thread reads zero, `inReady` is 1 and `errPulse` is 0.
- R2: An operand whose flag is 0 is its 16-bit field zero-extended to 32 bits. An operand whose flag is 1 is the issuing thread's register selected by the low 2 bits of the field; the upper field bits are ignored.
- R3: A result is written only to register `inDest` of thread `inThread`. The registers of other threads, and other registers of the same thread, keep their values.
- R4: Code 0 (move) writes the right operand unchanged; the left operand has no effect.
- R5: Code 1 (add), code 2 (left minus right) and code 3 (multiply) keep the low 32 bits of the result.
- R6: Code 8 is XOR, code 10 is OR and code 11 is AND, each bit by bit.
- R7: Code 9 writes the bitwise inverse of the right operand; the left operand has no effect.
- R8: Code 12 shifts left and code 13 shifts right logically. The shift amount is the low 5 bits of the right operand, and zeros fill the vacated bits.
- R9: Codes 4–7, 14 and 15 change no register. `errPulse` is 1 for exactly the one cycle after that handshake, and 0 after any other cycle.
- R10: The read port shows the new value in the cycle right after the handshake. An instruction issued in that cycle that reads the same register uses the new value.
- R11: While `inValid` is 0, no register changes, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction present |
| inReady | output | 1 | Unit accepts an instruction this cycle |
| inThread | input | 2 | Issuing thread |
| inDest | input | 2 | Destination register index |
| opCode | input | 4 | Operation code |
| lhsIsReg | input | 1 | Left operand names a register |
| lhsField | input | 16 | Left operand literal or register index |
| rhsIsReg | input | 1 | Right operand names a register |
| rhsField | input | 16 | Right operand literal or register index |
| errPulse | output | 1 | One-cycle flag after an undefined code |
| rdThread | input | 2 | Observation port thread select |
| rdIdx | input | 2 | Observation port register select |
| rdData | output | 32 | Observation port data, forwarded |

## Verification
The bench builds the unit with its defaults: 4 threads, 4 registers per thread, 32-bit registers and 16-bit operand fields. With these values every thread/register pair can be swept after a run, and the upper field bits can be filled with noise to show that only the low 2 bits select a register. A 16-bit literal cannot reach the full 32-bit range on its own, so chains of move, shift and OR build all-ones words. These words drive add and multiply past their wrap point. Shift amounts of 32 and above test the 5-bit truncation, and back-to-back dependent instructions exercise the forwarding path.

// File: rtl/spr_alu_pkg.sv
package spr_alu_pkg;

  localparam int OPC_W = 4;

  // Internal operation selector, dense, decoded from the sparse opcode.
  typedef enum logic [3:0] {
    SEL_MOVE = 4'd0,
    SEL_ADD  = 4'd1,
    SEL_SUB  = 4'd2,
    SEL_MUL  = 4'd3,
    SEL_XOR  = 4'd4,
    SEL_NOT  = 4'd5,
    SEL_OR   = 4'd6,
    SEL_AND  = 4'd7,
    SEL_SHL  = 4'd8,
    SEL_SHR  = 4'd9
  } aluSel_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic    wrEn;
    aluSel_e sel;
  } ctrlStrobe_t;

endpackage

// File: rtl/spr_alu_core.sv
module spr_alu_core
  import spr_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W = $clog2(DATA_W)
) (
  input  aluSel_e             sel,
  input  logic [DATA_W-1:0]   lhs,
  input  logic [DATA_W-1:0]   rhs,
  output logic [DATA_W-1:0]   res
);

  logic [SH_W-1:0] shAmt;
  assign shAmt = rhs[SH_W-1:0];

  always_comb begin
    case (sel)
      SEL_MOVE: res = rhs;
      SEL_ADD:  res = lhs + rhs;
      SEL_SUB:  res = lhs - rhs;
      SEL_MUL:  res = lhs * rhs;
      SEL_XOR:  res = lhs ^ rhs;
      SEL_NOT:  res = ~rhs;
      SEL_OR:   res = lhs | rhs;
      SEL_AND:  res = lhs & rhs;
      SEL_SHL:  res = lhs << shAmt;
      SEL_SHR:  res = lhs >> shAmt;
      default:  res = rhs;
    endcase
  end

endmodule

// File: rtl/spr_alu_ctrl.sv
module spr_alu_ctrl
  import spr_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opCode,
  output logic             inReady,
  output logic             errPulse,
  output ctrlStrobe_t      strobe
);

  logic    readyQ;
  logic    errQ;
  logic    accept;
  logic    legal;
  aluSel_e sel;

  assign accept = inValid & readyQ;

  // Sparse opcode map: 0..3 arithmetic, 8..13 bitwise and shift.
  always_comb begin
    legal = 1'b1;
    sel   = SEL_MOVE;
    case (opCode)
      4'd0:    sel = SEL_MOVE;
      4'd1:    sel = SEL_ADD;
      4'd2:    sel = SEL_SUB;
      4'd3:    sel = SEL_MUL;
      4'd8:    sel = SEL_XOR;
      4'd9:    sel = SEL_NOT;
      4'd10:   sel = SEL_OR;
      4'd11:   sel = SEL_AND;
      4'd12:   sel = SEL_SHL;
      4'd13:   sel = SEL_SHR;
      default: legal = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      readyQ <= 1'b1;
      errQ   <= accept & ~legal;
    end
  end

  assign inReady     = readyQ;
  assign errPulse    = errQ;
  assign strobe.wrEn = accept & legal;
  assign strobe.sel  = sel;

endmodule

// File: rtl/spr_alu_dp.sv
module spr_alu_dp
  import spr_alu_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SPR_COUNT   = 4,
  parameter int DATA_W      = 32,
  parameter int FIELD_W     = 16,
  localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W = (SPR_COUNT > 1) ? $clog2(SPR_COUNT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [THR_W-1:0]   inThread,
  input  logic [IDX_W-1:0]   inDest,
  input  logic               lhsIsReg,
  input  logic [FIELD_W-1:0] lhsField,
  input  logic               rhsIsReg,
  input  logic [FIELD_W-1:0] rhsField,
  input  logic [THR_W-1:0]   rdThread,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DATA_W-1:0]  rdData
);

  // Write-back stage: result waits here one cycle before entering the bank.
  logic              wbValidQ;
  logic [THR_W-1:0]  wbThrQ;
  logic [IDX_W-1:0]  wbIdxQ;
  logic [DATA_W-1:0] wbDataQ;

  logic [NUM_THREADS-1:0][SPR_COUNT-1:0][DATA_W-1:0] sprAll;

  genvar t;
  generate
    for (t = 0; t < NUM_THREADS; t++) begin : g_bank
      logic [SPR_COUNT-1:0][DATA_W-1:0] bankQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          bankQ <= '0;
        end else if (wbValidQ && (wbThrQ == THR_W'(t))) begin
          bankQ[wbIdxQ] <= wbDataQ;
        end
      end
      assign sprAll[t] = bankQ;
    end
  endgenerate

  // Register read with forwarding from the pending write-back.
  function automatic logic [DATA_W-1:0] fwdRead(
    input logic [THR_W-1:0] thr,
    input logic [IDX_W-1:0] idx
  );
    if (wbValidQ && (wbThrQ == thr) && (wbIdxQ == idx)) begin
      return wbDataQ;
    end
    return sprAll[thr][idx];
  endfunction

  logic [DATA_W-1:0] lhsVal;
  logic [DATA_W-1:0] rhsVal;
  logic [DATA_W-1:0] aluRes;

  always_comb begin
    lhsVal = lhsIsReg ? fwdRead(inThread, lhsField[IDX_W-1:0]) : DATA_W'(lhsField);
    rhsVal = rhsIsReg ? fwdRead(inThread, rhsField[IDX_W-1:0]) : DATA_W'(rhsField);
    rdData = fwdRead(rdThread, rdIdx);
  end

  spr_alu_core #(.DATA_W(DATA_W)) core_i (
    .sel (strobe.sel),
    .lhs (lhsVal),
    .rhs (rhsVal),
    .res (aluRes)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbValidQ <= 1'b0;
      wbThrQ   <= '0;
      wbIdxQ   <= '0;
      wbDataQ  <= '0;
    end else begin
      wbValidQ <= strobe.wrEn;
      if (strobe.wrEn) begin
        wbThrQ  <= inThread;
        wbIdxQ  <= inDest;
        wbDataQ <= aluRes;
      end
    end
  end

endmodule

// File: rtl/spr_alu.sv
module spr_alu
  import spr_alu_pkg::*;
#(
  parameter int NUM_THREADS = 4,
  parameter int SPR_COUNT   = 4,
  parameter int DATA_W      = 32,
  parameter int FIELD_W     = 16,
  localparam int THR_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int IDX_W = (SPR_COUNT > 1) ? $clog2(SPR_COUNT) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [THR_W-1:0]   inThread,
  input  logic [IDX_W-1:0]   inDest,
  input  logic [OPC_W-1:0]   opCode,
  input  logic               lhsIsReg,
  input  logic [FIELD_W-1:0] lhsField,
  input  logic               rhsIsReg,
  input  logic [FIELD_W-1:0] rhsField,
  output logic               errPulse,
  input  logic [THR_W-1:0]   rdThread,
  input  logic [IDX_W-1:0]   rdIdx,
  output logic [DATA_W-1:0]  rdData
);

  ctrlStrobe_t strobe;

  spr_alu_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .inReady  (inReady),
    .errPulse (errPulse),
    .strobe   (strobe)
  );

  spr_alu_dp #(
    .NUM_THREADS (NUM_THREADS),
    .SPR_COUNT   (SPR_COUNT),
    .DATA_W      (DATA_W),
    .FIELD_W     (FIELD_W)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .inThread (inThread),
    .inDest   (inDest),
    .lhsIsReg (lhsIsReg),
    .lhsField (lhsField),
    .rhsIsReg (rhsIsReg),
    .rhsField (rhsField),
    .rdThread (rdThread),
    .rdIdx    (rdIdx),
    .rdData   (rdData)
  );

endmodule

// File: rtl/spr_alu_chk.sv
module spr_alu_chk #(
  parameter int THR_W   = 2,
  parameter int IDX_W   = 2,
  parameter int DATA_W  = 32,
  parameter int FIELD_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inReady,
  input logic [THR_W-1:0]   inThread,
  input logic [IDX_W-1:0]   inDest,
  input logic [3:0]         opCode,
  input logic               lhsIsReg,
  input logic [FIELD_W-1:0] lhsField,
  input logic               rhsIsReg,
  input logic [FIELD_W-1:0] rhsField,
  input logic               errPulse,
  input logic [THR_W-1:0]   rdThread,
  input logic [IDX_W-1:0]   rdIdx,
  input logic [DATA_W-1:0]  rdData
);

  logic accepted;
  logic undefinedCode;
  logic immAdd;
  logic prevAcc;
  logic [DATA_W-1:0] immSum;

  assign accepted      = inValid && inReady;
  assign undefinedCode = (opCode inside {4'd4, 4'd5, 4'd6, 4'd7, 4'd14, 4'd15});
  assign immAdd        = accepted && (opCode == 4'd1) && !lhsIsReg && !rhsIsReg;
  assign immSum        = DATA_W'(lhsField) + DATA_W'(rhsField);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevAcc <= 1'b0;
    else       prevAcc <= accepted;
  end

  // R9
  err_on_undefined_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && undefinedCode) |=> errPulse);

  // R9
  no_err_on_defined_chk: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !undefinedCode) |=> !errPulse);

  // R11
  no_err_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accepted |=> !errPulse);

  // R11
  read_stable_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(rdThread) && $stable(rdIdx) && !prevAcc) |-> $stable(rdData));

  // R5
  imm_add_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    immAdd |=> ((rdThread != $past(inThread)) || (rdIdx != $past(inDest)) ||
                (rdData == $past(immSum))));

endmodule

bind spr_alu spr_alu_chk #(
  .THR_W   (THR_W),
  .IDX_W   (IDX_W),
  .DATA_W  (DATA_W),
  .FIELD_W (FIELD_W)
) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .inThread (inThread),
  .inDest   (inDest),
  .opCode   (opCode),
  .lhsIsReg (lhsIsReg),
  .lhsField (lhsField),
  .rhsIsReg (rhsIsReg),
  .rhsField (rhsField),
  .errPulse (errPulse),
  .rdThread (rdThread),
  .rdIdx    (rdIdx),
  .rdData   (rdData)
);

// File: tb/spr_alu_tb_top.sv
`timescale 1ns/1ps
module spr_alu_tb_top;

  localparam int NT = 4;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inThread = '0;
  logic [1:0]  inDest = '0;
  logic [3:0]  opCode = '0;
  logic        lhsIsReg = 1'b0;
  logic [15:0] lhsField = '0;
  logic        rhsIsReg = 1'b0;
  logic [15:0] rhsField = '0;
  logic        errPulse;
  logic [1:0]  rdThread = '0;
  logic [1:0]  rdIdx = '0;
  logic [31:0] rdData;

  int checkCnt = 0;
  int failCnt  = 0;
  logic [31:0] model [NT][NS];

  always #4 clk = ~clk;

  spr_alu dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inThread(inThread), .inDest(inDest), .opCode(opCode),
    .lhsIsReg(lhsIsReg), .lhsField(lhsField), .rhsIsReg(rhsIsReg),
    .rhsField(rhsField), .errPulse(errPulse), .rdThread(rdThread),
    .rdIdx(rdIdx), .rdData(rdData)
  );

  function automatic bit refLegal(input logic [3:0] op);
    return (op <= 4'd3) || (op >= 4'd8 && op <= 4'd13);
  endfunction

  function automatic logic [31:0] refAlu(input logic [3:0] op,
                                         input logic [31:0] a, input logic [31:0] b);
    case (op)
      4'd0:  return b;
      4'd1:  return a + b;
      4'd2:  return a - b;
      4'd3:  return a * b;
      4'd8:  return a ^ b;
      4'd9:  return ~b;
      4'd10: return a | b;
      4'd11: return a & b;
      4'd12: return a << b[4:0];
      4'd13: return a >> b[4:0];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string opTag(input logic [3:0] op);
    case (op)
      4'd0: return "R4";
      4'd1, 4'd2, 4'd3: return "R5";
      4'd8, 4'd10, 4'd11: return "R6";
      4'd9: return "R7";
      4'd12, 4'd13: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  // Called just after a falling edge; issues one instruction and checks it
  // in the cycle that follows (R10: new value visible through forwarding).
  task automatic issue(input logic [1:0] thr, input logic [1:0] dst,
                       input logic [3:0] op,
                       input logic lr, input logic [15:0] lf,
                       input logic rr, input logic [15:0] rf);
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    bit ok;
    a   = lr ? model[thr][lf[1:0]] : {16'h0, lf};   // R2
    b   = rr ? model[thr][rf[1:0]] : {16'h0, rf};
    res = refAlu(op, a, b);
    ok  = refLegal(op);
    inThread = thr; inDest = dst; opCode = op;
    lhsIsReg = lr; lhsField = lf; rhsIsReg = rr; rhsField = rf;
    inValid = 1'b1;
    @(posedge clk);
    if (ok) model[thr][dst] = res;                   // R3
    @(negedge clk);
    inValid  = 1'b0;
    rdThread = thr;
    rdIdx    = dst;
    #1;
    chk({opTag(op), " R10 result"}, rdData, model[thr][dst]);
    chk("R9 errPulse", {31'h0, errPulse}, {31'h0, !ok});
  endtask

  // Sweep every register of every thread with inValid low and noisy inputs.
  task automatic sweep(input string tag);
    for (int t = 0; t < NT; t++) begin
      for (int s = 0; s < NS; s++) begin
        @(negedge clk);
        inValid  = 1'b0;
        opCode   = 4'($urandom);
        inThread = 2'($urandom);
        inDest   = 2'($urandom);
        lhsField = 16'($urandom);
        rhsField = 16'($urandom);
        rdThread = 2'(t);
        rdIdx    = 2'(s);
        #1;
        chk(tag, rdData, model[t][s]);
      end
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < NT; t++)
      for (int s = 0; s < NS; s++)
        model[t][s] = 32'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk("R1 inReady", {31'h0, inReady}, 32'h1);
    chk("R1 errPulse", {31'h0, errPulse}, 32'h0);
    sweep("R1 reset value");

    @(negedge clk);
    // Build all-ones in thread 1 reg 0 through back-to-back dependents.
    issue(2'd1, 2'd0, 4'd0,  1'b0, 16'h1234, 1'b0, 16'hFFFF);   // R4 move
    issue(2'd1, 2'd0, 4'd12, 1'b1, 16'hFFF0, 1'b0, 16'd16);     // R2 noisy index, R8
    issue(2'd1, 2'd0, 4'd10, 1'b1, 16'h0000, 1'b0, 16'hFFFF);   // R6
    issue(2'd1, 2'd1, 4'd1,  1'b1, 16'h0004, 1'b0, 16'h0001);   // R5 add wraps to 0
    issue(2'd1, 2'd2, 4'd2,  1'b0, 16'h0000, 1'b0, 16'h0001);   // R5 sub wraps
    issue(2'd1, 2'd3, 4'd3,  1'b1, 16'h0000, 1'b1, 16'h0002);   // R5 mul low word
    issue(2'd1, 2'd3, 4'd13, 1'b1, 16'h0000, 1'b0, 16'd33);     // R8 amount mod 32
    issue(2'd2, 2'd0, 4'd9,  1'b0, 16'hABCD, 1'b0, 16'h00FF);   // R7
    issue(2'd1, 2'd0, 4'd5,  1'b0, 16'h0001, 1'b0, 16'h0001);   // R9
    issue(2'd1, 2'd0, 4'd15, 1'b0, 16'h0001, 1'b0, 16'h0001);   // R9
    issue(2'd1, 2'd0, 4'd11, 1'b1, 16'h0000, 1'b1, 16'h0003);   // R6 and
    issue(2'd3, 2'd2, 4'd8,  1'b1, 16'h0000, 1'b0, 16'h5A5A);   // R6 xor, thread 3
    sweep("R3 R11 isolation");

    for (int n = 0; n < 400; n++) begin
      issue(2'($urandom), 2'($urandom), 4'($urandom),
            1'($urandom), 16'($urandom), 1'($urandom), 16'($urandom));
      if (($urandom % 8) == 0) begin
        @(negedge clk);
        inValid = 1'b0;
        opCode  = 4'($urandom);
      end
      if ((n % 100) == 99) sweep("R3 R11 random sweep");
    end
    @(negedge clk);
    #1;
    chk("R9 pulse ends", {31'h0, errPulse}, 32'h0);
    finishRun();
  end

endmodule